// File: doc/BRIEF.md
# DCT Butterfly Unit with Layer Scaling

This block is the processing element of an in-place fast real DCT over 512 points. While a layer is open it takes one operand pair per cycle, forms a sum and a cosine-weighted difference, and returns both results, with their write addresses, to the working store one cycle later. In the opening layer of a transform the operands come straight from the audio sample buffer. In every later layer they come from the working store.

The working store holds 13-bit results, but the datapath takes 12-bit operands. While a layer runs, the block keeps the largest result magnitude it has written. When the layer closes, that peak picks a right shift of 0 to 3 bits. The shift is applied to every working-store operand of the next layer, followed by saturation to the 12-bit range. The shifts are summed into a block exponent so that downstream logic can undo the scaling. Address sequencing and the recombination layers that follow the butterflies belong to the surrounding controller.

The controller has three states. In `S_IDLE` no layer is open. `S_RUN` accepts pairs. `S_DRAIN` is a single cycle in which the scale is chosen. The transitions are: open (`S_IDLE`→`S_RUN` on `layer_start`), close (`S_RUN`→`S_DRAIN` on `layer_end`) and settle (`S_DRAIN`→`S_IDLE`, unconditional).

Top module: `dct_bfly_scaler`

## Requirements
- R1: While reset is held and after it is released, `wr_en`, `layer_busy`, `layer_peak`, `scale_shift`, `exponent`, `wr_y1` and `wr_y2` are all 0.
- R2: A pair accepted in cycle t appears in cycle t+1. At that point `wr_en`=1, the addresses are copied through, `wr_y1` = x1+x2 and `wr_y2` = floor((x1−x2)·coef / 128). Both results are 13-bit two's complement.
- R3: A layer opened with `first_layer`=1 takes its operands from `aud_a`/`aud_b` unchanged. A layer opened with `first_layer`=0 takes them from `wrk_a`/`wrk_b`.
- R4: `layer_peak` is cleared when a layer opens. After each write it holds the largest |wr_y1| or |wr_y2| written so far in the layer.
- R5: One cycle after the close, in the settle cycle, `scale_shift` becomes the smallest s in 0..3 with (peak >> s) ≤ 2047, or 3 if no such s exists.
- R6: A working-store operand is first shifted right arithmetically by `scale_shift` and then saturated to [−2048, 2047].
- R7: At each close, `exponent` grows by the selected shift, modulo 64. Opening a layer with `first_layer`=1 clears both `exponent` and `scale_shift`.
- R8: `pair_valid` has no effect outside `S_RUN`, and none in the cycle that carries `layer_end`. No write follows in either case.
- R9: `layer_start` is ignored while a layer is running or draining. `layer_busy` is 1 exactly in `S_RUN` and `S_DRAIN`.
- R10: Pairs given on consecutive cycles produce writes on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| layer_start | input | 1 | Opens a layer when idle |
| first_layer | input | 1 | Sampled with layer_start; 1 selects the audio buffer and restarts the exponent |
| layer_end | input | 1 | Closes the running layer |
| pair_valid | input | 1 | An operand pair is present this cycle |
| rd_addr_a | input | 9 | Store address of the first operand |
| rd_addr_b | input | 9 | Store address of the second operand |
| aud_a | input | 12 | First audio operand, signed |
| aud_b | input | 12 | Second audio operand, signed |
| wrk_a | input | 13 | First working-store operand, signed |
| wrk_b | input | 13 | Second working-store operand, signed |
| coef | input | 8 | Cosine weight, signed, 7 fraction bits |
| wr_en | output | 1 | Write strobe for the result pair |
| wr_addr_a | output | 9 | Write address for wr_y1 |
| wr_addr_b | output | 9 | Write address for wr_y2 |
| wr_y1 | output | 13 | Sum result, signed |
| wr_y2 | output | 13 | Weighted difference result, signed |
| layer_busy | output | 1 | A layer is running or draining |
| layer_peak | output | 13 | Largest result magnitude of the current layer |
| scale_shift | output | 2 | Shift applied to working-store operands |
| exponent | output | 6 | Accumulated scaling since the transform began |

## Verification
The assertions assume that `layer_end` comes only while a layer is running, and that the working store returns values no larger than the peak recorded for the previous layer. Only under that second assumption does the chosen shift bring every operand into 12 bits without saturation. The stimulus honours the first assumption throughout. It breaks the second one on purpose: in one layer it feeds full-scale values under a zero shift, so the saturation path runs while the properties stay true. Control strobes such as a stray `layer_start`, or `pair_valid` while idle or alongside `layer_end`, are placed at the edges where the state machine changes state.

// File: rtl/dctb_pkg.sv
package dctb_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_DRAIN = 2'd2
    } bfly_state_e;
endpackage

// File: rtl/bfly_core.sv
// Combinational butterfly: sum and coefficient-weighted difference,
// both aligned to one (DATA_W+1)-bit integer format.
module bfly_core #(
    parameter int DATA_W    = 12,
    parameter int COEF_W    = 8,
    parameter int COEF_FRAC = 7,
    localparam int SUM_W    = DATA_W + 1,
    localparam int PROD_W   = SUM_W + COEF_W
) (
    input  logic signed [DATA_W-1:0] x1,
    input  logic signed [DATA_W-1:0] x2,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [SUM_W-1:0]  y1,
    output logic signed [SUM_W-1:0]  y2
);
    logic signed [SUM_W-1:0]  diff;
    logic signed [PROD_W-1:0] prod;
    logic                     prod_edge_unused;

    always_comb begin
        y1   = SUM_W'(x1) + SUM_W'(x2);
        diff = SUM_W'(x1) - SUM_W'(x2);
        prod = PROD_W'(diff) * PROD_W'(coef);
        // dropping the fraction bits is a floor division by 2**COEF_FRAC
        y2   = prod[COEF_FRAC +: SUM_W];
    end

    assign prod_edge_unused = ^{prod[COEF_FRAC-1:0], prod[PROD_W-1]};
endmodule

// File: rtl/operand_scaler.sv
// Read-side block scaling: arithmetic right shift, then clamp to DATA_W bits.
module operand_scaler #(
    parameter int DATA_W  = 12,
    parameter int SHIFT_W = 2,
    localparam int WORK_W = DATA_W + 1
) (
    input  logic signed [WORK_W-1:0] w_in,
    input  logic [SHIFT_W-1:0]       shift,
    output logic signed [DATA_W-1:0] x_out
);
    localparam int HI = (1 << (DATA_W - 1)) - 1;
    localparam int LO = -(1 << (DATA_W - 1));

    logic signed [WORK_W-1:0] shifted;

    always_comb begin
        shifted = w_in >>> shift;
        if (int'(shifted) > HI)
            x_out = DATA_W'(HI);
        else if (int'(shifted) < LO)
            x_out = DATA_W'(LO);
        else
            x_out = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/peak_track.sv
// Largest result magnitude seen since the last clear.
module peak_track #(
    parameter int W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                upd,
    input  logic signed [W-1:0] v1,
    input  logic signed [W-1:0] v2,
    output logic [W-1:0]        peak
);
    logic [W-1:0] m1, m2, big;

    always_comb begin
        m1  = v1[W-1] ? (~v1 + 1'b1) : v1;
        m2  = v2[W-1] ? (~v2 + 1'b1) : v2;
        big = (m1 > m2) ? m1 : m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            peak <= '0;
        else if (clr)
            peak <= '0;
        else if (upd && big > peak)
            peak <= big;
    end
endmodule

// File: rtl/dct_bfly_scaler.sv
module dct_bfly_scaler
    import dctb_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int COEF_W    = 8,
    parameter int COEF_FRAC = 7,
    parameter int POINTS    = 512,
    parameter int MAX_SHIFT = 3,
    parameter int EXP_W     = 6,
    localparam int WORK_W   = DATA_W + 1,
    localparam int ADDR_W   = $clog2(POINTS),
    localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     layer_start,
    input  logic                     first_layer,
    input  logic                     layer_end,
    input  logic                     pair_valid,
    input  logic [ADDR_W-1:0]        rd_addr_a,
    input  logic [ADDR_W-1:0]        rd_addr_b,
    input  logic signed [DATA_W-1:0] aud_a,
    input  logic signed [DATA_W-1:0] aud_b,
    input  logic signed [WORK_W-1:0] wrk_a,
    input  logic signed [WORK_W-1:0] wrk_b,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr_a,
    output logic [ADDR_W-1:0]        wr_addr_b,
    output logic signed [WORK_W-1:0] wr_y1,
    output logic signed [WORK_W-1:0] wr_y2,
    output logic                     layer_busy,
    output logic [WORK_W-1:0]        layer_peak,
    output logic [SHIFT_W-1:0]       scale_shift,
    output logic [EXP_W-1:0]         exponent
);
    localparam int LIM = (1 << (DATA_W - 1)) - 1;

    bfly_state_e state_q, state_d;
    logic accept, open_lyr, close_lyr;
    logic src_audio_q;
    logic [SHIFT_W-1:0] shift_q, shift_sel;
    logic [EXP_W-1:0]   exp_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (layer_start) state_d = S_RUN;
            S_RUN:   if (layer_end)   state_d = S_DRAIN;
            S_DRAIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        accept     = 1'b0;
        open_lyr   = 1'b0;
        close_lyr  = 1'b0;
        layer_busy = 1'b0;
        unique case (state_q)
            S_IDLE:  open_lyr = layer_start;
            S_RUN: begin
                layer_busy = 1'b1;
                accept     = pair_valid && !layer_end;
            end
            S_DRAIN: begin
                layer_busy = 1'b1;
                close_lyr  = 1'b1;
            end
            default: ;
        endcase
    end

    // ---------------- operand fetch and scaling ----------------
    logic signed [WORK_W-1:0] wrk_in [2];
    logic signed [DATA_W-1:0] wrk_x  [2];
    logic signed [DATA_W-1:0] op1, op2;

    assign wrk_in[0] = wrk_a;
    assign wrk_in[1] = wrk_b;

    for (genvar i = 0; i < 2; i++) begin : g_scl
        operand_scaler #(
            .DATA_W (DATA_W),
            .SHIFT_W(SHIFT_W)
        ) u_scl (
            .w_in (wrk_in[i]),
            .shift(shift_q),
            .x_out(wrk_x[i])
        );
    end

    assign op1 = src_audio_q ? aud_a : wrk_x[0];
    assign op2 = src_audio_q ? aud_b : wrk_x[1];

    logic signed [WORK_W-1:0] y1_c, y2_c;

    bfly_core #(
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .COEF_FRAC(COEF_FRAC)
    ) u_core (
        .x1  (op1),
        .x2  (op2),
        .coef(coef),
        .y1  (y1_c),
        .y2  (y2_c)
    );

    // ---------------- result register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_addr_a <= '0;
            wr_addr_b <= '0;
            wr_y1     <= '0;
            wr_y2     <= '0;
        end else begin
            wr_en <= accept;
            if (accept) begin
                wr_addr_a <= rd_addr_a;
                wr_addr_b <= rd_addr_b;
                wr_y1     <= y1_c;
                wr_y2     <= y2_c;
            end
        end
    end

    peak_track #(.W(WORK_W)) u_peak (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (open_lyr),
        .upd  (wr_en),
        .v1   (wr_y1),
        .v2   (wr_y2),
        .peak (layer_peak)
    );

    // ---------------- scale choice and exponent ----------------
    always_comb begin
        shift_sel = SHIFT_W'(MAX_SHIFT);
        for (int s = MAX_SHIFT - 1; s >= 0; s--)
            if (int'(layer_peak >> s) <= LIM) shift_sel = SHIFT_W'(s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_audio_q <= 1'b0;
            shift_q     <= '0;
            exp_q       <= '0;
        end else if (open_lyr) begin
            src_audio_q <= first_layer;
            if (first_layer) begin
                shift_q <= '0;
                exp_q   <= '0;
            end
        end else if (close_lyr) begin
            shift_q <= shift_sel;
            exp_q   <= exp_q + EXP_W'(shift_sel);
        end
    end

    assign scale_shift = shift_q;
    assign exponent    = exp_q;

    // ---------------- assertions ----------------
    // R4
    peak_covers_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (layer_peak >= $past($unsigned(wr_y1[WORK_W-1] ? -wr_y1 : wr_y1))));

    // R4
    peak_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != S_IDLE) |-> (layer_peak >= $past(layer_peak)));

    // R5
    shift_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_DRAIN) |->
            ((int'(layer_peak >> scale_shift) <= LIM) || (int'(scale_shift) == MAX_SHIFT)));

    // R7
    exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) != S_DRAIN) &&
         !$past(state_q == S_IDLE && layer_start && first_layer)) |-> $stable(exponent));

    // R8
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !wr_en);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && layer_start && !layer_end) |=> (state_q == S_RUN));
endmodule

// File: tb/sim_dct_bfly_scaler.sv
module sim_dct_bfly_scaler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic layer_start = 0, first_layer = 0, layer_end = 0, pair_valid = 0;
    logic [8:0] rd_addr_a = '0, rd_addr_b = '0;
    logic signed [11:0] aud_a = '0, aud_b = '0;
    logic signed [12:0] wrk_a = '0, wrk_b = '0;
    logic signed [7:0]  coef = '0;
    logic wr_en, layer_busy;
    logic [8:0] wr_addr_a, wr_addr_b;
    logic signed [12:0] wr_y1, wr_y2;
    logic [12:0] layer_peak;
    logic [1:0] scale_shift;
    logic [5:0] exponent;

    always #4 clk = ~clk;

    dct_bfly_scaler u0 (
        .clk(clk), .rst_n(rst_n), .layer_start(layer_start), .first_layer(first_layer),
        .layer_end(layer_end), .pair_valid(pair_valid), .rd_addr_a(rd_addr_a),
        .rd_addr_b(rd_addr_b), .aud_a(aud_a), .aud_b(aud_b), .wrk_a(wrk_a), .wrk_b(wrk_b),
        .coef(coef), .wr_en(wr_en), .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b),
        .wr_y1(wr_y1), .wr_y2(wr_y2), .layer_busy(layer_busy), .layer_peak(layer_peak),
        .scale_shift(scale_shift), .exponent(exponent)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state (0 idle, 1 run, 2 drain)
    int m_state = 0, m_src = 0, m_shift = 0, m_exp = 0, m_peak = 0;
    int m_wen = 0, m_y1 = 0, m_y2 = 0, m_aa = 0, m_ab = 0;

    function automatic int sat12(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int mag(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int pick_shift(int p);
        for (int s = 0; s < 3; s++)
            if ((p >> s) <= 2047) return s;
        return 3;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R8",  "wr_en",       int'(wr_en), m_wen);
        chk("R2",  "wr_addr_a",   int'(wr_addr_a), m_aa);
        chk("R2",  "wr_addr_b",   int'(wr_addr_b), m_ab);
        chk("R2",  "wr_y1",       int'(wr_y1), m_y1);
        chk("R6",  "wr_y2",       int'(wr_y2), m_y2);
        chk("R9",  "layer_busy",  int'(layer_busy), (m_state != 0) ? 1 : 0);
        chk("R4",  "layer_peak",  int'(layer_peak), m_peak);
        chk("R5",  "scale_shift", int'(scale_shift), m_shift);
        chk("R7",  "exponent",    int'(exponent), m_exp);
    endtask

    // one clock: drive at the falling edge, advance the model, compare at the next falling edge
    task automatic cyc(bit ls, bit fl, bit le, bit pv, int xa, int xb, int wa, int wb,
                       int c, int aa, int ab);
        int acc, x1, x2, n_peak, s;
        layer_start = ls; first_layer = fl; layer_end = le; pair_valid = pv;
        aud_a = 12'(xa); aud_b = 12'(xb); wrk_a = 13'(wa); wrk_b = 13'(wb);
        coef = 8'(c); rd_addr_a = 9'(aa); rd_addr_b = 9'(ab);

        acc = (m_state == 1 && pv && !le) ? 1 : 0;
        if (m_state == 0 && ls) n_peak = 0;
        else if (m_wen != 0) begin
            n_peak = m_peak;
            if (mag(m_y1) > n_peak) n_peak = mag(m_y1);
            if (mag(m_y2) > n_peak) n_peak = mag(m_y2);
        end else n_peak = m_peak;

        if (acc != 0) begin
            x1 = (m_src != 0) ? xa : sat12(wa >>> m_shift);
            x2 = (m_src != 0) ? xb : sat12(wb >>> m_shift);
            m_y1 = x1 + x2;
            m_y2 = ((x1 - x2) * c) >>> 7;
            m_aa = aa; m_ab = ab;
        end
        m_wen = acc;

        if (m_state == 0 && ls) begin
            m_src = fl;
            if (fl) begin m_shift = 0; m_exp = 0; end
            m_state = 1;
        end else if (m_state == 2) begin
            s = pick_shift(m_peak);
            m_shift = s;
            m_exp = (m_exp + s) & 63;
            m_state = 0;
        end else if (m_state == 1 && le) begin
            m_state = 2;
        end
        m_peak = n_peak;

        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom_range(hi - lo, 0));
    endfunction

    // mode 0: full-range audio, 1: small audio, 2: random work, 3: extreme work (R6)
    task automatic run_layer(bit first, int npairs, int mode);
        int xa, xb, c;
        cyc(1, first, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < npairs; k++) begin
            c = rnd(-128, 127);
            case (mode)
                0: begin xa = rnd(-2048, 2047); xb = rnd(-2048, 2047); end
                1: begin xa = rnd(-400, 400);   xb = rnd(-400, 400);   end
                2: begin xa = rnd(-4096, 4095); xb = rnd(-4096, 4095); end
                default: begin xa = (k % 2) ? 4095 : -4096; xb = (k % 2) ? -4096 : 4095; end
            endcase
            // corner pairs at the start of the full-range audio layer (R2)
            if (mode == 0 && k == 0) begin xa = -2048; xb = -2048; c = 64; end
            if (mode == 0 && k == 1) begin xa = -2048; xb = 2047;  c = -128; end
            if (mode == 0 && k == 2) begin xa = 2047;  xb = 2047;  c = 127; end
            if (mode >= 2) // R3: audio inputs carry noise that must be ignored
                cyc((k == 4), 0, 0, 1, rnd(-2048, 2047), rnd(-2048, 2047), xa, xb, c,
                    rnd(0, 511), rnd(0, 511));
            else begin
                // R10 back-to-back pairs, with a gap on k==6 and a stray start on k==4 (R9)
                cyc((k == 4), 0, 0, (k != 6), xa, xb, rnd(-4096, 4095), rnd(-4096, 4095), c,
                    rnd(0, 511), rnd(0, 511));
            end
        end
        // R8: pair offered together with the close
        cyc(0, 0, 1, 1, 100, -100, 100, -100, 50, 1, 2);
        // drain cycle: stray start and pair (R8, R9)
        cyc(1, 0, 0, 1, 5, 6, 7, 8, 9, 3, 4);
        // idle cycle with a pair offered (R8)
        cyc(0, 0, 0, 1, 11, 12, 13, 14, 15, 5, 6);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all();                   // R1 reset state while held
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();                   // R1 reset state after release
        run_layer(1, 24, 0);             // peak 4096 -> shift 2
        run_layer(0, 24, 2);
        run_layer(0, 16, 3);
        run_layer(0, 0, 2);              // empty layer -> peak 0 -> shift 0
        run_layer(1, 24, 1);             // restart clears exponent (R7), small peak
        run_layer(0, 16, 3);             // saturation under zero shift (R6)
        run_layer(0, 24, 2);
        finished = 1;
        report();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            report();
            $finish;
        end
    end
endmodule